// File: doc/BRIEF.md
# Sequential Unsigned Multiply/Divide Unit

This block multiplies or divides two 8-bit unsigned operands over several clock cycles, handling one operand bit per clock. Its two results live in a pair of fixed result registers: an accumulator (A) and a companion register (B). A multiply leaves the low byte of the 16-bit product in A and the high byte in B. A divide leaves the quotient in A and the remainder in B.

A caller gives a one-cycle start pulse with the operation select and both operands. It then watches `busy`, and takes the results and flags when `done` pulses. When the unit is idle, B is an ordinary 8-bit register. The caller writes it through `b_wr`.

Multiplication uses shift-and-add. Division uses restoring subtraction. Both share one working register of twice the operand width plus one bit.

Top module: `muldiv_unit`

## Requirements
- R1: With `op_div`=0, the 16-bit product of `a_in`×`b_in` goes to the outputs: low byte on `a_out`, high byte on `b_out`. For example, 50h×A0h gives `a_out`=00h and `b_out`=32h.
- R2: With `op_div`=1 and a nonzero divisor, `a_out` receives the quotient of `a_in`/`b_in` and `b_out` the remainder, and `ovf` is cleared. For example, FBh/12h gives 0Dh and 11h.
- R3: A multiply sets `ovf` when the product exceeds FFh and clears it otherwise. `carry` reads 0 after every operation.
- R4: A divide with `b_in`=00h sets `ovf` and leaves `a_out` and `b_out` at their previous values. Its `done` comes 2 clocks after the start edge instead of 10.
- R5: Take the rising edge that samples `start` while idle as edge 0. `busy` is high from edge 0 to edge 10, for exactly 10 cycles. `done` is high for exactly the one cycle after edge 10, which is also the cycle in which the results first appear.
- R6: A `start` pulse while `busy` is high is ignored. The operation in flight finishes with its original operands, and no second operation follows.
- R7: `a_out` and `b_out` hold their values while an operation is in progress. They change only at completion.
- R8: When idle, `b_wr`=1 loads `b_in` into `b_out` at the next edge without touching `a_out`. While busy, `b_wr` is ignored.
- R9: After reset, `a_out`, `b_out`, `ovf`, `carry`, `busy` and `done` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin an operation |
| op_div | input | 1 | Operation select: 0 multiply, 1 divide |
| a_in | input | 8 | Multiplier or dividend |
| b_in | input | 8 | Multiplicand or divisor; also the data for an idle write of B |
| b_wr | input | 1 | Idle write strobe for the B register |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| a_out | output | 8 | A register: product low byte or quotient |
| b_out | output | 8 | B register: product high byte or remainder |
| carry | output | 1 | Carry flag, cleared by every operation |
| ovf | output | 1 | Overflow: wide product or divide by zero |

## Verification
Counted from the edge that samples `start`, `busy` is due one cycle later. `done` and the results are due after edge 10 for a normal operation and after edge 2 for a zero divisor. An idle write of B shows one cycle after its edge. Inputs change on the falling clock edge and outputs are read there. Each scenario counts falling edges from its start pulse, so a missing or mistimed `done` is reported against that index, not just detected eventually. In every cycle before `done`, the bench also checks that `busy` is high and that A and B have not moved. In the cycle after `done`, it checks that `done` has dropped.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_ITER = 2'd2,
    ST_WB   = 2'd3
  } md_state_e;
endpackage

// File: rtl/muldiv_ctrl.sv
module muldiv_ctrl
  import muldiv_pkg::*;
#(
  parameter int N = 8,
  localparam int CNT_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic zero_div,
  output logic capture,
  output logic step,
  output logic writeback,
  output logic busy
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(N - 1);

  md_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    capture   = 1'b0;
    step      = 1'b0;
    writeback = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start) begin
        capture = 1'b1;
        state_d = ST_LOAD;
      end
      ST_LOAD: begin
        cnt_d   = '0;
        state_d = zero_div ? ST_WB : ST_ITER;
      end
      ST_ITER: begin
        step  = 1'b1;
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == LAST) state_d = ST_WB;
      end
      ST_WB: begin
        writeback = 1'b1;
        state_d   = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign busy = (state_q != ST_IDLE);

  // R5: the iteration phase is not cut short before its last count
  a_r5_iter_runs_full: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ITER && cnt_q != LAST) |=> (state_q == ST_ITER));

  // R6: a request seen while occupied never launches a new load
  a_r6_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE && start) |=> (state_q != ST_LOAD));

endmodule

// File: rtl/muldiv_dp.sv
module muldiv_dp #(
  parameter int N = 8,
  localparam int W = 2 * N + 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         capture,
  input  logic         step,
  input  logic         op_div,
  input  logic [N-1:0] a_in,
  input  logic [N-1:0] b_in,
  output logic         op_is_div,
  output logic         zero_div,
  output logic         wide,
  output logic [N-1:0] res_lo,
  output logic [N-1:0] res_hi
);

  logic         div_q, div_d;
  logic [N-1:0] opb_q, opb_d;
  logic [W-1:0] work_q, work_d;

  logic [N:0]   add_sum;
  logic [W-1:0] shl;
  logic [N+1:0] diff;

  always_comb begin
    add_sum = work_q[W-1:N] + {1'b0, opb_q};
    shl     = work_q << 1;
    diff    = {1'b0, shl[W-1:N]} - {2'b00, opb_q};
  end

  always_comb begin
    div_d  = div_q;
    opb_d  = opb_q;
    work_d = work_q;
    if (capture) begin
      div_d  = op_div;
      opb_d  = b_in;
      work_d = {{(N+1){1'b0}}, a_in};
    end else if (step) begin
      if (div_q) begin
        if (!diff[N+1]) work_d = {diff[N:0], shl[N-1:1], 1'b1};
        else            work_d = shl;
      end else begin
        if (work_q[0]) work_d = {add_sum, work_q[N-1:0]} >> 1;
        else           work_d = work_q >> 1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= 1'b0;
      opb_q  <= '0;
      work_q <= '0;
    end else begin
      div_q  <= div_d;
      opb_q  <= opb_d;
      work_q <= work_d;
    end
  end

  assign op_is_div = div_q;
  assign zero_div  = div_q && (opb_q == '0);
  assign wide      = |work_q[2*N-1:N];
  assign res_lo    = work_q[N-1:0];
  assign res_hi    = work_q[2*N-1:N];

  // R2: after every division step the partial remainder stays below the divisor
  a_r2_rem_below_divisor: assert property (@(posedge clk) disable iff (!rst_n)
    (step && div_q) |=> (work_q[2*N-1:N] < opb_q));

endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         op_div,
  input  logic [N-1:0] a_in,
  input  logic [N-1:0] b_in,
  input  logic         b_wr,
  output logic         busy,
  output logic         done,
  output logic [N-1:0] a_out,
  output logic [N-1:0] b_out,
  output logic         carry,
  output logic         ovf
);

  logic         capture, step, writeback;
  logic         op_is_div, zero_div, wide;
  logic [N-1:0] res_lo, res_hi;

  logic [N-1:0] a_q, a_d, b_q, b_d;
  logic         ovf_q, ovf_d, done_q;

  muldiv_ctrl #(.N(N)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .zero_div  (zero_div),
    .capture   (capture),
    .step      (step),
    .writeback (writeback),
    .busy      (busy)
  );

  muldiv_dp #(.N(N)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (capture),
    .step      (step),
    .op_div    (op_div),
    .a_in      (a_in),
    .b_in      (b_in),
    .op_is_div (op_is_div),
    .zero_div  (zero_div),
    .wide      (wide),
    .res_lo    (res_lo),
    .res_hi    (res_hi)
  );

  always_comb begin
    a_d   = a_q;
    b_d   = b_q;
    ovf_d = ovf_q;
    if (writeback) begin
      if (zero_div) begin
        ovf_d = 1'b1;
      end else begin
        a_d   = res_lo;
        b_d   = res_hi;
        ovf_d = op_is_div ? 1'b0 : wide;
      end
    end else if (b_wr && !busy) begin
      b_d = b_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q    <= '0;
      b_q    <= '0;
      ovf_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      a_q    <= a_d;
      b_q    <= b_d;
      ovf_q  <= ovf_d;
      done_q <= writeback;
    end
  end

  assign a_out = a_q;
  assign b_out = b_q;
  assign ovf   = ovf_q;
  assign done  = done_q;
  assign carry = 1'b0;

  // R5: completion is a single-cycle pulse
  a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7: results frozen while the unit is occupied
  a_r7_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(a_out) && $stable(b_out)));

  // R4: a zero-divisor completion keeps both result registers
  a_r4_div0_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ovf && op_is_div) |-> ($stable(a_out) && $stable(b_out)));

  // R8: an idle write lands in B on the next edge
  a_r8_idle_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && b_wr) |=> (b_out == $past(b_in)));

endmodule

// File: tb/test_muldiv_unit.sv
`timescale 1ns/1ps
module test_muldiv_unit;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start, op_div, b_wr;
  logic [7:0] a_in, b_in;
  logic       busy, done, carry, ovf;
  logic [7:0] a_out, b_out;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  muldiv_unit i_muldiv_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .op_div(op_div),
    .a_in(a_in), .b_in(b_in), .b_wr(b_wr),
    .busy(busy), .done(done), .a_out(a_out), .b_out(b_out),
    .carry(carry), .ovf(ovf)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Runs one operation; optionally pokes start/b_wr mid-flight (R6, R8)
  task automatic run_op(input logic div, input logic [7:0] a, input logic [7:0] b,
                        input bit poke, input string name);
    logic [7:0] ea, eb, pa, pb;
    logic       eo;
    int         due, seen;
    pa = a_out; pb = b_out;
    if (!div) begin
      ea = 8'((16'(a) * 16'(b)) & 16'hFF);
      eb = 8'((16'(a) * 16'(b)) >> 8);
      eo = (16'(a) * 16'(b)) > 16'hFF;
      due = 10;
    end else if (b == 8'h00) begin
      ea = pa; eb = pb; eo = 1'b1; due = 2;
    end else begin
      ea = a / b; eb = a % b; eo = 1'b0; due = 10;
    end
    @(negedge clk);
    start = 1'b1; op_div = div; a_in = a; b_in = b;
    @(negedge clk);
    start = 1'b0; a_in = 8'h00; b_in = 8'h00;
    chk({name, " R5 busy after start"}, busy, 1);
    seen = 0;
    for (int i = 1; i <= 14; i++) begin
      if (poke && i == 3) begin
        start = 1'b1; op_div = ~div; a_in = 8'hE7; b_in = 8'h3C; b_wr = 1'b1;
      end else if (poke && i == 4) begin
        start = 1'b0; a_in = 8'h00; b_in = 8'h00; b_wr = 1'b0;
      end
      @(negedge clk);
      if (done) begin seen = i; break; end
      if (a_out != pa || b_out != pb || !busy) begin
        chk({name, " R7 hold/busy in flight"}, {busy, a_out, b_out}, {1'b1, pa, pb});
      end
    end
    if (poke) begin
      start = 1'b0; b_wr = 1'b0;
    end
    chk({name, " R5 done index"}, seen, due);
    chk({name, " R5 busy low at done"}, busy, 0);
    chk({name, div ? " R2/R4 A" : " R1 A"}, a_out, ea);
    chk({name, div ? " R2/R4 B" : " R1 B"}, b_out, eb);
    chk({name, " R3/R4 ovf"}, ovf, eo);
    chk({name, " R3 carry"}, carry, 0);
    @(negedge clk);
    chk({name, " R5 done one cycle"}, done, 0);
    if (poke) begin
      repeat (3) @(negedge clk);
      chk({name, " R6 no second run"}, busy, 0);
      chk({name, " R6/R8 B after poke"}, b_out, eb);
    end
  endtask

  task automatic t_reset();
    chk("R9 A reset", a_out, 0);
    chk("R9 B reset", b_out, 0);
    chk("R9 flags reset", {ovf, carry}, 0);
    chk("R9 busy/done reset", {busy, done}, 0);
  endtask

  task automatic t_idle_write();
    logic [7:0] pa;
    pa = a_out;
    @(negedge clk);
    b_wr = 1'b1; b_in = 8'h5A;
    @(negedge clk);
    b_wr = 1'b0; b_in = 8'h00;
    chk("R8 idle B write", b_out, 8'h5A);
    chk("R8 A untouched", a_out, pa);
    chk("R8 not busy", busy, 0);
  endtask

  initial begin
    #800000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; op_div = 1'b0; b_wr = 1'b0;
    a_in = 8'h00; b_in = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    run_op(1'b0, 8'h50, 8'hA0, 1'b0, "mul 50*A0");
    run_op(1'b1, 8'hFB, 8'h12, 1'b0, "div FB/12");
    run_op(1'b0, 8'h03, 8'h05, 1'b0, "mul 03*05");
    run_op(1'b0, 8'hFF, 8'hFF, 1'b0, "mul FF*FF");
    run_op(1'b1, 8'h77, 8'h00, 1'b0, "div by zero");
    run_op(1'b1, 8'h05, 8'h09, 1'b0, "div 05/09");
    run_op(1'b1, 8'hC8, 8'h01, 1'b0, "div C8/01");
    run_op(1'b0, 8'h12, 8'h34, 1'b1, "mul 12*34 poked");
    t_idle_write();
    run_op(1'b0, 8'h00, 8'hFF, 1'b0, "mul 00*FF");
    run_op(1'b1, 8'hFF, 8'hFF, 1'b0, "div FF/FF");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule